// File: doc/BRIEF.md
# DMA Address and Byte Counter

This block keeps the working state of a bus-master DMA transfer in a network controller: a 32-bit system memory address, the remaining size of the current transmit or receive buffer, and a pointer to the descriptor of the previous transmitted frame. The bus interface unit advances the address and the count one step at a time with single-cycle increment commands while a transfer runs. A host register port exposes all three values as 16-bit registers inside 32-bit accesses.

The byte count is held as a negative number in 12-bit two's complement, and it counts up toward zero. A flag marks when it is empty. Host writes to the address and count are accepted only while the controller is stopped or suspended. The descriptor pointer takes the address of each transmit descriptor just before that descriptor is written back, but only while the controller is running. While halted, the host can load the pointer through a separate alias select. Each register has its own reset rule. The address is never reset. A hard reset clears the count and the pointer.

Top module: `dma_ptr_regs`

## Requirements
- R1: Select 0 reads the lower address half and select 1 reads the upper address half in bits 15:0, with bits 31:16 read as zero. These reads return the value only while `stop_i` or `susp_i` is high. Otherwise they return all zeros.
- R2: A pulse on `addr_inc_i` adds one to the full 32-bit address. A carry out of the lower half reaches the upper half in the same cycle.
- R3: Host writes (select 0 lower address, 1 upper address, 2 count, 4 pointer alias) take effect only while `stop_i` or `susp_i` is high. Either one alone is enough. At any other time the write leaves the register unchanged.
- R4: When a host write and an increment command arrive in the same cycle, the write wins. A write to either address half cancels that cycle's address increment. A count write cancels that cycle's count increment.
- R5: A hard reset leaves the DMA address unchanged.
- R6: Select 2 reads the 12-bit count in bits 11:0 with ones in bits 15:12, while halted. A count write takes only bits 11:0 of the write data. Each `cnt_inc_i` pulse adds one to a nonzero count.
- R7: `cnt_zero_o` is high exactly when the count is zero. An increment command at zero is ignored, so the count never wraps.
- R8: A hard reset sets the count to zero (`cnt_zero_o` high) and the previous-descriptor pointer to zero.
- R9: A pulse on `desc_wb_i` while neither `stop_i` nor `susp_i` is high loads `desc_addr_i` into the pointer. The pulse is ignored while the controller is halted.
- R10: Select 3 reads the pointer in bits 15:0 at all times, and writes to select 3 are ignored. The pointer is written through select 4, subject to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| stop_i | input | 1 | Controller stopped status |
| susp_i | input | 1 | Controller suspended status |
| reg_sel_i | input | 3 | Register select for host read and write |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 16 | Host write data (upper access bits are zero by definition) |
| reg_rdata_o | output | 32 | Host read data for the selected register |
| addr_inc_i | input | 1 | Address increment command from the bus interface unit |
| cnt_inc_i | input | 1 | Byte count increment command from the bus interface unit |
| desc_wb_i | input | 1 | Transmit descriptor write-back is about to happen |
| desc_addr_i | input | 16 | Lower address of the descriptor being written back |
| dma_addr_o | output | 32 | Current DMA memory address |
| byte_cnt_o | output | 12 | Remaining byte count, negative two's complement |
| cnt_zero_o | output | 1 | Count has reached zero |
| prev_desc_o | output | 16 | Previous transmit descriptor pointer |

## Verification
The hardest state to reach is the carry from the lower to the upper address half. From reset the address is arbitrary, so the stimulus first loads it, while halted, with a lower half two steps below the wrap point. It then releases the halt and issues increments, so the carry is seen only when the upper half is read back. The count boundary is reached the same way. A count of minus three is loaded and stepped to zero, further increments are applied at zero, and then a hard reset is applied. The reset must clear the count and the pointer and leave the loaded address in place.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;

   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_ADDR_LO    = 3'd0,
      SEL_ADDR_HI    = 3'd1,
      SEL_COUNT      = 3'd2,
      SEL_PREV       = 3'd3,
      SEL_PREV_ALIAS = 3'd4
   } reg_sel_e;

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int HALF_W = 16,
   parameter int HALVES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       inc_i,
   input  logic [HALVES-1:0]          wr_en_i,
   input  logic [HALF_W-1:0]          wr_data_i,
   output logic [HALF_W*HALVES-1:0]   addr_o
);
   localparam int ADDR_W = HALF_W * HALVES;

   logic [HALF_W-1:0] half_q [HALVES];
   logic [ADDR_W-1:0] addr_next;
   logic              any_wr;

   initial begin
      assert (HALVES >= 1 && HALF_W >= 1)
         else $error("dma_addr_ctr: bad geometry");
   end

   assign any_wr    = |wr_en_i;
   assign addr_next = addr_o + 1'b1;

   // Each half has its own register with no reset. A write to any half
   // cancels the increment for the whole address.
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_ff @(posedge clk) begin
         if (wr_en_i[h])
            half_q[h] <= wr_data_i;
         else if (inc_i && !any_wr)
            half_q[h] <= addr_next[h*HALF_W +: HALF_W];
      end
      assign addr_o[h*HALF_W +: HALF_W] = half_q[h];
   end

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !any_wr) |=> addr_o == $past(addr_o) + 1'b1);

   assert_wr_wins_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i[0] |=> addr_o[HALF_W-1:0] == $past(wr_data_i));

endmodule

// File: rtl/dma_byte_ctr.sv
module dma_byte_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   assign zero_o = (cnt_q == '0);
   assign cnt_o  = cnt_q;

   // The count is the negative of the bytes left and it counts up to zero.
   // It stops at zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_en_i)
         cnt_q <= wr_data_i;
      else if (inc_i && !zero_o)
         cnt_q <= cnt_q + 1'b1;
   end

   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_en_i && cnt_o == '0) |=> cnt_o == '0);

   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_en_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) + 1'b1);

   assert_cnt_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> cnt_o == $past(wr_data_i));

endmodule

// File: rtl/dma_prev_ptr.sv
module dma_prev_ptr #(
   parameter int PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic [PTR_W-1:0] cap_addr_i,
   input  logic             wr_en_i,
   input  logic [PTR_W-1:0] wr_data_i,
   output logic [PTR_W-1:0] ptr_o
);
   logic [PTR_W-1:0] ptr_q;

   // The capture and the host write are gated by opposite halt states,
   // so they never arrive in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (wr_en_i)
         ptr_q <= wr_data_i;
      else if (cap_i)
         ptr_q <= cap_addr_i;
   end

   assign ptr_o = ptr_q;

   assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> ptr_o == $past(cap_addr_i));

   assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !wr_en_i) |=> $stable(ptr_o));

   assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_i && wr_en_i));

endmodule

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
   import dma_ptr_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int BUS_W  = 32,
   parameter int CNT_W  = 12,
   parameter int PTR_W  = 16,
   localparam int ADDR_W = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_i,
   input  logic              susp_i,
   input  logic [SEL_W-1:0]  reg_sel_i,
   input  logic              reg_wr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [BUS_W-1:0]  reg_rdata_o,
   input  logic              addr_inc_i,
   input  logic              cnt_inc_i,
   input  logic              desc_wb_i,
   input  logic [PTR_W-1:0]  desc_addr_i,
   output logic [ADDR_W-1:0] dma_addr_o,
   output logic [CNT_W-1:0]  byte_cnt_o,
   output logic              cnt_zero_o,
   output logic [PTR_W-1:0]  prev_desc_o
);
   localparam int PAD_W = REG_W - CNT_W;

   initial begin
      assert (CNT_W < REG_W) else $error("dma_ptr_regs: CNT_W must be below REG_W");
      assert (PTR_W <= REG_W) else $error("dma_ptr_regs: PTR_W exceeds REG_W");
      assert (BUS_W >= REG_W) else $error("dma_ptr_regs: BUS_W below REG_W");
   end

   reg_sel_e   sel;
   logic       halted;
   logic       host_wr;
   logic [1:0] addr_wr;
   logic       cnt_wr;
   logic       ptr_wr;
   logic       ptr_cap;

   assign sel     = reg_sel_e'(reg_sel_i);
   assign halted  = stop_i | susp_i;
   assign host_wr = reg_wr_i & halted;

   assign addr_wr[0] = host_wr && sel == SEL_ADDR_LO;
   assign addr_wr[1] = host_wr && sel == SEL_ADDR_HI;
   assign cnt_wr     = host_wr && sel == SEL_COUNT;
   assign ptr_wr     = host_wr && sel == SEL_PREV_ALIAS;
   assign ptr_cap    = desc_wb_i & ~halted;

   dma_addr_ctr #(.HALF_W(REG_W), .HALVES(2)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (addr_inc_i),
      .wr_en_i   (addr_wr),
      .wr_data_i (reg_wdata_i),
      .addr_o    (dma_addr_o)
   );

   dma_byte_ctr #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (cnt_inc_i),
      .wr_en_i   (cnt_wr),
      .wr_data_i (reg_wdata_i[CNT_W-1:0]),
      .cnt_o     (byte_cnt_o),
      .zero_o    (cnt_zero_o)
   );

   dma_prev_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_i      (ptr_cap),
      .cap_addr_i (desc_addr_i),
      .wr_en_i    (ptr_wr),
      .wr_data_i  (reg_wdata_i[PTR_W-1:0]),
      .ptr_o      (prev_desc_o)
   );

   // Read mux. The address and count read as zero while the controller runs.
   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         SEL_ADDR_LO: if (halted) reg_rdata_o = BUS_W'(dma_addr_o[REG_W-1:0]);
         SEL_ADDR_HI: if (halted) reg_rdata_o = BUS_W'(dma_addr_o[ADDR_W-1:REG_W]);
         SEL_COUNT:   if (halted) reg_rdata_o = BUS_W'({{PAD_W{1'b1}}, byte_cnt_o});
         SEL_PREV:    reg_rdata_o = BUS_W'(prev_desc_o);
         default:     reg_rdata_o = '0;
      endcase
   end

   assert_host_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !addr_inc_i) |=> $stable(dma_addr_o));

   assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc_i && !cnt_wr && byte_cnt_o == '1) |=> cnt_zero_o);

   assert_rd_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && sel == SEL_ADDR_HI) |-> reg_rdata_o == '0);

endmodule

// File: tb/dma_ptr_regs_test.sv
module dma_ptr_regs_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stop_i = 1'b0, susp_i = 1'b0;
   logic [2:0]  reg_sel_i = '0;
   logic        reg_wr_i = 1'b0;
   logic [15:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        addr_inc_i = 1'b0, cnt_inc_i = 1'b0, desc_wb_i = 1'b0;
   logic [15:0] desc_addr_i = '0;
   logic [31:0] dma_addr_o;
   logic [11:0] byte_cnt_o;
   logic        cnt_zero_o;
   logic [15:0] prev_desc_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_ptr_regs uut (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .susp_i(susp_i),
      .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .addr_inc_i(addr_inc_i), .cnt_inc_i(cnt_inc_i),
      .desc_wb_i(desc_wb_i), .desc_addr_i(desc_addr_i), .dma_addr_o(dma_addr_o),
      .byte_cnt_o(byte_cnt_o), .cnt_zero_o(cnt_zero_o), .prev_desc_o(prev_desc_o)
   );

   // Vector fields: stop, wr, sel, wdata, ainc, cinc, read sel, expected read.
   localparam int NV = 23;
   localparam logic [57:0] VEC [NV] = '{
      {1'b1,1'b1,3'd0,16'hFFFE,1'b0,1'b0,3'd0,32'h0000FFFE}, // R1 R3
      {1'b1,1'b1,3'd1,16'h1234,1'b0,1'b0,3'd1,32'h00001234}, // R1
      {1'b0,1'b0,3'd0,16'h0000,1'b1,1'b0,3'd0,32'h00000000}, // R1 gated read
      {1'b0,1'b0,3'd0,16'h0000,1'b1,1'b0,3'd1,32'h00000000}, // R2 carry step
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd1,32'h00001235}, // R2 carry seen
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd0,32'h00000000}, // R2
      {1'b0,1'b1,3'd0,16'hAAAA,1'b0,1'b0,3'd0,32'h00000000}, // R3 blocked
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd0,32'h00000000}, // R3
      {1'b1,1'b1,3'd0,16'h5555,1'b1,1'b0,3'd0,32'h00005555}, // R4
      {1'b1,1'b1,3'd1,16'h0001,1'b1,1'b0,3'd0,32'h00005555}, // R4 inc cancelled
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd1,32'h00000001}, // R4
      {1'b1,1'b1,3'd2,16'hFFFD,1'b0,1'b0,3'd2,32'h0000FFFD}, // R6
      {1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,3'd3,32'h00000000}, // R10 R6
      {1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,3'd3,32'h00000000}, // R6
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd2,32'h0000FFFF}, // R6
      {1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,3'd2,32'h00000000}, // R7 gated
      {1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,3'd3,32'h00000000}, // R7 inc at zero
      {1'b1,1'b0,3'd0,16'h0000,1'b0,1'b0,3'd2,32'h0000F000}, // R7 no wrap
      {1'b1,1'b1,3'd2,16'h0ABC,1'b0,1'b0,3'd2,32'h0000FABC}, // R6 top bits
      {1'b1,1'b1,3'd3,16'hBEEF,1'b0,1'b0,3'd3,32'h00000000}, // R10 ignored
      {1'b1,1'b1,3'd4,16'hBEEF,1'b0,1'b0,3'd3,32'h0000BEEF}, // R10 alias
      {1'b0,1'b1,3'd4,16'h1111,1'b0,1'b0,3'd3,32'h0000BEEF}, // R3 R10
      {1'b1,1'b1,3'd2,16'h0FF0,1'b0,1'b1,3'd2,32'h0000FFF0}  // R4 count
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // Drive strobes now, then clear them at the next falling edge.
   task automatic step();
      @(negedge clk);
      reg_wr_i = 0; addr_inc_i = 0; cnt_inc_i = 0; desc_wb_i = 0;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R8 zero flag", 32'(cnt_zero_o), 32'h1);
      chk("R8 count", 32'(byte_cnt_o), 32'h0);
      chk("R8 pointer", 32'(prev_desc_o), 32'h0);

      for (int i = 0; i < NV; i++) begin
         {stop_i, reg_wr_i, reg_sel_i, reg_wdata_i, addr_inc_i, cnt_inc_i} = VEC[i][57:35];
         step();
         reg_sel_i = VEC[i][34:32];
         #1;
         chk($sformatf("R1-table vector %0d", i), reg_rdata_o, VEC[i][31:0]);
      end

      // R9: capture while running, ignored while suspended
      stop_i = 0; susp_i = 0;
      desc_wb_i = 1; desc_addr_i = 16'h4242;
      step();
      chk("R9 capture", 32'(prev_desc_o), 32'h4242);
      susp_i = 1; desc_wb_i = 1; desc_addr_i = 16'h9999;
      step();
      chk("R9 halted ignore", 32'(prev_desc_o), 32'h4242);

      // R3: suspend alone enables writes
      reg_wr_i = 1; reg_sel_i = 3'd0; reg_wdata_i = 16'h7777;
      step();
      chk("R3 suspend write", reg_rdata_o, 32'h00007777);
      chk("R2 full address", dma_addr_o, 32'h00017777);
      susp_i = 0;

      // R7: count from -1 to zero
      stop_i = 1; reg_wr_i = 1; reg_sel_i = 3'd2; reg_wdata_i = 16'hFFFF;
      step();
      chk("R7 not zero", 32'(cnt_zero_o), 32'h0);
      stop_i = 0; cnt_inc_i = 1;
      step();
      chk("R7 zero flag", 32'(cnt_zero_o), 32'h1);
      chk("R7 count", 32'(byte_cnt_o), 32'h0);

      // R5 R8: hard reset
      stop_i = 1; reg_wr_i = 1; reg_sel_i = 3'd2; reg_wdata_i = 16'hFFFD;
      step();
      rst_n = 0;
      repeat (2) @(negedge clk);
      #1;
      chk("R5 address kept", dma_addr_o, 32'h00017777);
      chk("R8 count cleared", 32'(byte_cnt_o), 32'h0);
      chk("R8 zero flag", 32'(cnt_zero_o), 32'h1);
      chk("R8 pointer cleared", 32'(prev_desc_o), 32'h0);
      rst_n = 1;
      step();
      finish_run();
   end
endmodule